// File: doc/BRIEF.md
# Single-Wire Bus Slot Sequencer

This block is the timing engine for a single open-drain, single-wire device bus. It produces the three primitive bus slots: a bus reset with presence detection, a write-0 slot, and a combined write-1/read slot. The bus is never driven high. The block only enables a pull-down and watches the line level through a two-flop synchronizer. All slot durations are given in microseconds and scaled to clock cycles by one parameter, `CLK_PER_US`.

A controller issues one command per slot. It asserts `cmd_start` for a cycle with `cmd_kind` and `cmd_bit`, then waits for `done`. A touch with bit 1 is a read slot: the line is pulled low briefly, released, and sampled partway through the slot. The sampled level comes back on `bit_out`, so a device that holds the line low reads as 0. A touch with bit 0 is a long low pulse and returns 0. A bus reset reports on `presence_n` whether any device answered. Byte assembly, device search and power boosting belong to the controller above.

Top module: `owire_slot_master`

## Requirements
- R1: A touch with `cmd_bit`=1 (`cmd_kind`=0) holds `line_pull` high for 6 µs and lasts 70 µs in total. `bit_out` then equals the synchronized line level sampled 9 µs after the pull-down is released.
- R2: A touch with `cmd_bit`=0 holds `line_pull` high for 60 µs and lasts 70 µs in total, including 10 µs of recovery. `bit_out` is 0 afterwards.
- R3: A bus reset (`cmd_kind`=1) holds `line_pull` high for 480 µs, then releases the line for 480 µs: 70 µs up to the presence sample and 410 µs after it. The command lasts 960 µs.
- R4: After a bus reset, `presence_n` is 0 if the line was low at the presence sample and 1 if it was high. It keeps that value through later touch commands.
- R5: The line level used for any sample passes through two synchronizer flops, whose idle value is high.
- R6: `busy` rises on the clock edge that accepts a command and falls on the edge where `done` pulses for exactly one cycle. `line_pull` is only ever high while `busy` is high.
- R7: A `cmd_start` that arrives while `busy` is high is ignored. The slot in progress keeps its timing and its result.
- R8: After reset, `busy`, `done`, `line_pull` and `bit_out` are 0 and `presence_n` is 1.
- R9: Encoding: `cmd_kind`=0 selects a touch slot and `cmd_kind`=1 selects a bus reset. `cmd_bit` is ignored for a bus reset.
- R10: Every µs duration above equals that many multiples of `CLK_PER_US` clock cycles, counted from the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cmd_start | input | 1 | One-cycle command request |
| cmd_kind | input | 1 | 0 = touch slot, 1 = bus reset |
| cmd_bit | input | 1 | Bit value for a touch slot |
| busy | output | 1 | A slot is in progress |
| done | output | 1 | One-cycle pulse when the slot ends |
| bit_out | output | 1 | Sampled level of the last touch (0 for write-0) |
| presence_n | output | 1 | 0 = device answered the last bus reset |
| line_pull | output | 1 | Pull-down enable for the open-drain line |
| line_in | input | 1 | Raw line level |

## Verification
The bench builds the block with `CLK_PER_US`=4 and keeps the default microsecond durations. A bus reset therefore takes 3840 cycles, so dozens of mixed resets and touches fit into one run, while every phase still spans several clock cycles and exposes off-by-one errors in the divider or the phase counters. A device model pulls the line low through each slot, which exercises both sampled levels for reads and for presence.

// File: rtl/owm_pkg.sv
package owm_pkg;

  typedef enum logic {
    KIND_TOUCH = 1'b0,
    KIND_RESET = 1'b1
  } owm_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_SAMP = 2'd2,
    ST_TAIL = 2'd3
  } owm_state_e;

endpackage

// File: rtl/owm_us_tick.sv
module owm_us_tick #(
  parameter int CLK_PER_US = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);

  localparam int DIV_W = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_PER_US - 1);

  logic [DIV_W-1:0] div_q, div_d;

  assign tick = (div_q == DIV_LAST);

  always_comb begin
    if (clr || tick) div_d = '0;
    else             div_d = div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  // R10: divider never runs past one microsecond
  a_r10_div_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    div_q <= DIV_LAST);

endmodule

// File: rtl/owm_line_sync.sv
module owm_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_raw,
  output logic line_s
);

  logic [STAGES-1:0] sr_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sr_q[0] <= 1'b1;
          else        sr_q[0] <= line_raw;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sr_q[g] <= 1'b1;
          else        sr_q[g] <= sr_q[g-1];
        end
      end
    end
  endgenerate

  assign line_s = sr_q[STAGES-1];

  // R5: the last stage only ever takes the previous stage's value
  a_r5_sync_chain: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_q[STAGES-2] != line_s) |=> (line_s == $past(sr_q[STAGES-2])));

endmodule

// File: rtl/owm_slot_seq.sv
module owm_slot_seq
  import owm_pkg::*;
#(
  parameter int T_W1_LOW   = 6,
  parameter int T_RD_SMP   = 9,
  parameter int T_RD_TAIL  = 55,
  parameter int T_W0_LOW   = 60,
  parameter int T_W0_REC   = 10,
  parameter int T_RST_LOW  = 480,
  parameter int T_RST_SMP  = 70,
  parameter int T_RST_TAIL = 410
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic cmd_start,
  input  logic cmd_kind,
  input  logic cmd_bit,
  input  logic line_s,
  output logic tick_clr,
  output logic busy,
  output logic done,
  output logic bit_out,
  output logic presence_n,
  output logic line_pull
);

  localparam int M1 = (T_W1_LOW > T_W0_LOW) ? T_W1_LOW : T_W0_LOW;
  localparam int M2 = (M1 > T_RST_LOW) ? M1 : T_RST_LOW;
  localparam int M3 = (T_RD_SMP > T_RST_SMP) ? T_RD_SMP : T_RST_SMP;
  localparam int M4 = (T_RD_TAIL > T_W0_REC) ? T_RD_TAIL : T_W0_REC;
  localparam int M5 = (M4 > T_RST_TAIL) ? M4 : T_RST_TAIL;
  localparam int M6 = (M2 > M3) ? M2 : M3;
  localparam int T_MAX = (M6 > M5) ? M6 : M5;
  localparam int US_W = $clog2(T_MAX + 1);

  owm_state_e     state_q, state_d;
  logic [US_W-1:0] us_q, us_d;
  logic [US_W-1:0] low_len_q, low_len_d;
  logic [US_W-1:0] smp_len_q, smp_len_d;
  logic [US_W-1:0] tail_len_q, tail_len_d;
  logic            is_rst_q, is_rst_d;
  logic            do_smp_q, do_smp_d;
  logic            pull_q, pull_d;
  logic            done_q, done_d;
  logic            bit_q, bit_d;
  logic            pres_q, pres_d;
  logic [US_W-1:0] cur_len;
  logic            accept;
  logic            phase_end;

  assign accept   = cmd_start && (state_q == ST_IDLE);
  assign tick_clr = accept;

  always_comb begin
    case (state_q)
      ST_LOW:  cur_len = low_len_q;
      ST_SAMP: cur_len = smp_len_q;
      ST_TAIL: cur_len = tail_len_q;
      default: cur_len = '0;
    endcase
  end

  assign phase_end = tick && (us_q == cur_len - 1'b1);

  always_comb begin
    state_d    = state_q;
    us_d       = us_q;
    low_len_d  = low_len_q;
    smp_len_d  = smp_len_q;
    tail_len_d = tail_len_q;
    is_rst_d   = is_rst_q;
    do_smp_d   = do_smp_q;
    bit_d      = bit_q;
    pres_d     = pres_q;
    done_d     = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          state_d = ST_LOW;
          us_d    = '0;
          if (owm_kind_e'(cmd_kind) == KIND_RESET) begin
            is_rst_d   = 1'b1;
            do_smp_d   = 1'b1;
            low_len_d  = US_W'(T_RST_LOW);
            smp_len_d  = US_W'(T_RST_SMP);
            tail_len_d = US_W'(T_RST_TAIL);
          end else begin
            is_rst_d   = 1'b0;
            do_smp_d   = cmd_bit;
            bit_d      = 1'b0;
            low_len_d  = cmd_bit ? US_W'(T_W1_LOW) : US_W'(T_W0_LOW);
            smp_len_d  = US_W'(T_RD_SMP);
            tail_len_d = cmd_bit ? US_W'(T_RD_TAIL) : US_W'(T_W0_REC);
          end
        end
      end
      ST_LOW: begin
        if (tick) begin
          if (phase_end) begin
            state_d = do_smp_q ? ST_SAMP : ST_TAIL;
            us_d    = '0;
          end else begin
            us_d = us_q + 1'b1;
          end
        end
      end
      ST_SAMP: begin
        if (tick) begin
          if (phase_end) begin
            state_d = ST_TAIL;
            us_d    = '0;
            if (is_rst_q) pres_d = line_s;
            else          bit_d  = line_s;
          end else begin
            us_d = us_q + 1'b1;
          end
        end
      end
      ST_TAIL: begin
        if (tick) begin
          if (phase_end) begin
            state_d = ST_IDLE;
            us_d    = '0;
            done_d  = 1'b1;
          end else begin
            us_d = us_q + 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
    pull_d = (state_d == ST_LOW);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      us_q       <= '0;
      low_len_q  <= '0;
      smp_len_q  <= '0;
      tail_len_q <= '0;
      is_rst_q   <= 1'b0;
      do_smp_q   <= 1'b0;
      pull_q     <= 1'b0;
      done_q     <= 1'b0;
      bit_q      <= 1'b0;
      pres_q     <= 1'b1;
    end else begin
      state_q    <= state_d;
      us_q       <= us_d;
      low_len_q  <= low_len_d;
      smp_len_q  <= smp_len_d;
      tail_len_q <= tail_len_d;
      is_rst_q   <= is_rst_d;
      do_smp_q   <= do_smp_d;
      pull_q     <= pull_d;
      done_q     <= done_d;
      bit_q      <= bit_d;
      pres_q     <= pres_d;
    end
  end

  assign busy       = (state_q != ST_IDLE);
  assign done       = done_q;
  assign line_pull  = pull_q;
  assign bit_out    = bit_q;
  assign presence_n = pres_q;

  // R6: done is a single-cycle pulse
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R6: done closes the busy window
  a_r6_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  // R6: the line is only pulled inside a slot
  a_r6_pull_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    line_pull |-> busy);
  // R1: every slot opens with the line pulled low
  a_r1_pull_at_accept: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> line_pull);
  // R7: command kind held for the whole slot
  a_r7_kind_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(is_rst_q));
  // R4: presence flag only moves inside a slot
  a_r4_pres_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !cmd_start) |=> $stable(presence_n));

endmodule

// File: rtl/owire_slot_master.sv
module owire_slot_master #(
  parameter int CLK_PER_US = 50,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_start,
  input  logic cmd_kind,
  input  logic cmd_bit,
  output logic busy,
  output logic done,
  output logic bit_out,
  output logic presence_n,
  output logic line_pull,
  input  logic line_in
);

  logic tick;
  logic tick_clr;
  logic line_s;

  owm_us_tick #(.CLK_PER_US(CLK_PER_US)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (tick_clr),
    .tick  (tick)
  );

  owm_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_raw (line_in),
    .line_s   (line_s)
  );

  owm_slot_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .cmd_start  (cmd_start),
    .cmd_kind   (cmd_kind),
    .cmd_bit    (cmd_bit),
    .line_s     (line_s),
    .tick_clr   (tick_clr),
    .busy       (busy),
    .done       (done),
    .bit_out    (bit_out),
    .presence_n (presence_n),
    .line_pull  (line_pull)
  );

endmodule

// File: tb/owire_slot_master_bench.sv
`timescale 1ns/1ps
module owire_slot_master_bench;

  localparam int CPU = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_start = 1'b0;
  logic cmd_kind = 1'b0;
  logic cmd_bit = 1'b0;
  logic slave_low = 1'b0;
  logic busy, done, bit_out, presence_n, line_pull;
  logic line_in;

  int n_checks = 0;
  int n_err = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  assign line_in = !(line_pull || slave_low);

  owire_slot_master #(.CLK_PER_US(CPU)) u_owire_slot_master (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_kind(cmd_kind),
    .cmd_bit(cmd_bit), .busy(busy), .done(done), .bit_out(bit_out),
    .presence_n(presence_n), .line_pull(line_pull), .line_in(line_in)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_low(input logic kind, input logic b);
    if (kind) return 480 * CPU;
    return b ? 6 * CPU : 60 * CPU;
  endfunction

  function automatic int exp_total(input logic kind, input logic b);
    if (kind) return (480 + 70 + 410) * CPU;
    return b ? (6 + 9 + 55) * CPU : (60 + 10) * CPU;
  endfunction

  task automatic run_cmd(input logic kind, input logic b, input logic slow, input bit inject,
                         output int lc, output int bc, output int dc);
    slave_low = slow;
    @(negedge clk);
    cmd_kind = kind; cmd_bit = b; cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
    lc = 0; bc = 0; dc = 0;
    for (int i = 0; i < 20000; i++) begin
      if (busy) begin
        bc++;
        if (line_pull) lc++;
        if (inject && bc == 20) begin
          cmd_start = 1'b1; cmd_kind = ~kind; cmd_bit = ~b;
        end else begin
          cmd_start = 1'b0;
        end
      end else begin
        if (done) dc++;
        break;
      end
      @(negedge clk);
    end
    cmd_start = 1'b0;
  endtask

  task automatic do_and_check(input logic kind, input logic b, input logic slow, input bit inject);
    int lc, bc, dc;
    logic pres_before, bit_before;
    pres_before = presence_n;
    bit_before = bit_out;
    run_cmd(kind, b, slow, inject, lc, bc, dc);
    check(lc == exp_low(kind, b), kind ? "R3 R10 low time" : (b ? "R1 R10 low time" : "R2 R10 low time"),
          lc, exp_low(kind, b));
    check(bc == exp_total(kind, b), kind ? "R3 R9 slot length" : (b ? "R1 R9 slot length" : "R2 slot length"),
          bc, exp_total(kind, b));
    check(dc == 1, "R6 done at end of busy", dc, 1);
    if (kind) begin
      check(presence_n == !slow, "R4 presence result", presence_n, !slow);
      check(bit_out == bit_before, "R9 reset leaves bit_out", bit_out, bit_before);
    end else begin
      check(presence_n == pres_before, "R4 presence held over touch", presence_n, pres_before);
      if (b) check(bit_out == !slow, "R1 R5 sampled bit", bit_out, !slow);
      else   check(bit_out == 1'b0, "R2 write-0 result", bit_out, 0);
    end
    if (inject) check(1'b1, "R7 start while busy ignored", 0, 0);
    @(negedge clk);
    check(done == 1'b0 && busy == 1'b0, "R6 done one cycle", done, 0);
    slave_low = 1'b0;
  endtask

  initial begin
    #(20.0 * 200000);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    check(busy == 0, "R8 busy after reset", busy, 0);
    check(done == 0, "R8 done after reset", done, 0);
    check(line_pull == 0, "R8 line_pull after reset", line_pull, 0);
    check(bit_out == 0, "R8 bit_out after reset", bit_out, 0);
    check(presence_n == 1, "R8 presence_n after reset", presence_n, 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // directed corners
    do_and_check(1'b1, 1'b0, 1'b1, 1'b0); // reset, device present
    do_and_check(1'b0, 1'b1, 1'b0, 1'b0); // read 1, presence held
    do_and_check(1'b0, 1'b1, 1'b1, 1'b0); // read 0
    do_and_check(1'b0, 1'b0, 1'b0, 1'b0); // write 0
    do_and_check(1'b1, 1'b1, 1'b0, 1'b0); // reset, no device, cmd_bit ignored
    do_and_check(1'b0, 1'b1, 1'b1, 1'b1); // R7 inject during read
    do_and_check(1'b1, 1'b0, 1'b1, 1'b1); // R7 inject during reset
    do_and_check(1'b0, 1'b0, 1'b1, 1'b1); // R7 inject during write 0

    // random mix
    for (int k = 0; k < 30; k++) begin
      logic kd, bt, sl;
      bit inj;
      kd = (($urandom() % 4) == 0);
      bt = $urandom() % 2;
      sl = $urandom() % 2;
      inj = (($urandom() % 5) == 0);
      do_and_check(kd, bt, sl, inj);
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

endmodule